// File: doc/BRIEF.md
# Console Teletype Controller

This block connects a processor's byte-wide programmed-I/O port to a keyboard that delivers characters and to a printer that consumes them. The processor issues one of four operations per cycle: a command byte, a data read, a data write or a status sense. Read data and sense results come back combinationally in the same cycle. Keyboard characters arrive as one-cycle strobes, and a separate strobe reports a line break condition. Printer characters leave on a valid/ready stream.

A single busy flag carries the handshake with software, and its meaning follows a programmable direction. In read mode, busy low means a received character is waiting. In write mode, busy low means the printer has finished the last character. An interrupt request follows each busy-clear event when the block is armed. Characters are conditioned on the way in and on the way out:
- Uppercase-terminal mode folds lowercase letters to uppercase.
- A width option chooses between 7-bit and 8-bit characters.
- Half-duplex mode echoes received characters locally.
- In 7-bit output, NUL and DEL are dropped.

Printer back-pressure: once `pr_valid` rises, it stays high and `pr_data` stays stable until `pr_ready` accepts the byte. The only exception is a new data write, which replaces a character that has not yet been taken. A stalled printer simply holds the character until it is accepted. `cfg_ksr` and `cfg_wide` are quasi-static: change them only while no output is pending.

Top module: `conio_ctrl`

## Requirements
- R1: After reset the block is in read mode and full duplex, with no character pending, the interrupt disarmed and no request. A status sense returns 0x08, and `irq` and `pr_valid` are low.
- R2: The status sense byte carries:
  - overrun in bit 7;
  - break in bit 5;
  - busy in bit 3;
  - bit 2, set whenever overrun or break is set.
  All other bits are 0.
- R3: The command byte holds three 2-bit fields:
  - bits 7:6 control the interrupt: 01 arms it; 10 disarms it and withdraws any request.
  - bits 5:4 select duplex: 01 full, 10 half.
  - bits 3:2 select direction: 01 read, 10 write.
  In every field, 00 and 11 leave the setting unchanged.
- R4: When a command changes the direction, busy clears if the new mode is ready, and a request is raised if armed. Read mode is ready when a character is pending; write mode is ready when the printer path is idle. If the new mode is not ready, busy sets and any request is withdrawn.
- R5: A command that leaves the direction unchanged clears overrun.
- R6: A data read returns the receive buffer and clears the pending flag. In read mode it also sets busy and clears overrun.
- R7: A data write starts a printer transfer, and in write mode it sets busy. When the transfer completes in write mode, busy clears and a request is raised if armed.
- R8: A keyboard character sets the pending flag in either mode. In read mode it also clears busy, raises a request if armed, and sets overrun if a character was already pending.
- R9: Received characters are stored as follows:
  - with `cfg_ksr` high: the low 7 bits are folded to uppercase and stored with bit 7 set;
  - otherwise with `cfg_wide` high: all 8 bits are stored;
  - otherwise: the value is masked to 7 bits.
- R10: A break strobe sets the break bit and stores 0 in the receive buffer. In read mode it also clears busy and raises a request if armed. The break bit clears at the next keyboard poll tick, which occurs every POLL_PERIOD cycles.
- R11: In half duplex, each received character whose 7-bit value (after uppercase folding when `cfg_ksr` is high) is non-zero is sent to the printer. A zero value is not echoed.
- R12: On output:
  - `cfg_ksr` masks the character to 7 bits and folds it to uppercase;
  - otherwise `cfg_wide` selects 8 or 7 bits.
  Unless 8-bit output is in effect (`cfg_wide` high and `cfg_ksr` low), a resulting 0x00 or 0x7F is dropped without being presented, and the transfer still completes.
- R13: While the printer stalls, `pr_valid` stays high with the same `pr_data`. The character is delivered exactly once when `pr_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Processor operation strobe |
| op_kind | input | 2 | 0 command, 1 data read, 2 data write, 3 status sense |
| op_data | input | 8 | Command byte or write data |
| bus_rdata | output | 8 | Read data or status for the current operation, 0 otherwise |
| irq | output | 1 | Interrupt request |
| kb_valid | input | 1 | Keyboard character strobe |
| kb_data | input | 8 | Keyboard character |
| kb_break | input | 1 | Break condition strobe |
| pr_valid | output | 1 | Printer character valid |
| pr_data | output | 8 | Printer character |
| pr_ready | input | 1 | Printer accepts the character |
| cfg_ksr | input | 1 | Uppercase-terminal conditioning |
| cfg_wide | input | 1 | 8-bit characters when high |

## Verification
The bench targets four areas:
- **Busy flag on direction switches.** It switches direction with and without a pending character and with an idle printer. A design that tested the wrong condition would report ready when nothing is ready, or hang busy forever.
- **Overrun.** It sends two characters without a read between them, then checks that an unchanged-direction command clears the overrun. A design that got this wrong would hide lost input or keep flagging it.
- **Dropped characters and stalls.** NUL and DEL writes must complete without reaching the printer. A held stall must deliver the character exactly once; getting this wrong duplicates or loses output.
- **Break.** The break bit must be visible in the status byte and must clear after one poll period. A design that got this wrong would leave it set or never show it.

// File: rtl/conio_pkg.sv
package conio_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_RDATA = 2'd1,
    OP_WDATA = 2'd2,
    OP_SENSE = 2'd3
  } bus_op_e;

  // status bit positions
  localparam int ST_OVR  = 7;
  localparam int ST_BRK  = 5;
  localparam int ST_BUSY = 3;
  localparam int ST_EX   = 2;

  // command field low bits
  localparam int CF_INT = 6;
  localparam int CF_DUP = 4;
  localparam int CF_DIR = 2;

  function automatic logic [6:0] fold_upper(input logic [6:0] c);
    return (c >= 7'h61 && c <= 7'h7A) ? (c - 7'h20) : c;
  endfunction

  // 01 sets, 10 clears, others keep
  function automatic logic apply_field(input logic [1:0] f, input logic cur);
    case (f)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/conio_rx_cond.sv
module conio_rx_cond
  import conio_pkg::*;
#(
  parameter int POLL_PERIOD = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAR_W-1:0] kb_data,
  input  logic              cfg_ksr,
  input  logic              cfg_wide,
  output logic [CHAR_W-1:0] store_ch,
  output logic [6:0]        echo_ch,
  output logic              echo_nz,
  output logic              poll_tick
);
  localparam int PW = (POLL_PERIOD > 1) ? $clog2(POLL_PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(POLL_PERIOD - 1);

  logic [PW-1:0] cnt_q;
  logic [6:0]    low7;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (poll_tick) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign poll_tick = (cnt_q == LAST);

  always_comb begin
    low7    = cfg_ksr ? fold_upper(kb_data[6:0]) : kb_data[6:0];
    echo_ch = low7;
    echo_nz = (low7 != 7'd0);
    if (cfg_ksr)       store_ch = {1'b1, low7};
    else if (cfg_wide) store_ch = kb_data;
    else               store_ch = {1'b0, kb_data[6:0]};
  end

endmodule

// File: rtl/conio_tx_path.sv
module conio_tx_path
  import conio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              echo_stb,
  input  logic [6:0]        echo_data,
  input  logic              cfg_ksr,
  input  logic              cfg_wide,
  input  logic              pr_ready,
  output logic              pr_valid,
  output logic [CHAR_W-1:0] pr_data,
  output logic              tx_done,
  output logic              tx_idle
);
  logic [CHAR_W-1:0] tx_buf_q;
  logic              tx_act_q;
  logic [6:0]        echo_q;
  logic              echo_pend_q;
  logic              tx_lock_q;
  logic [CHAR_W-1:0] cond;
  logic              drop;
  logic              sel_echo;
  logic              full8;

  always_comb begin
    full8 = cfg_wide && !cfg_ksr;
    if (cfg_ksr)    cond = {1'b0, fold_upper(tx_buf_q[6:0])};
    else if (full8) cond = tx_buf_q;
    else            cond = {1'b0, tx_buf_q[6:0]};
    drop     = !full8 && (cond == 8'h00 || cond == 8'h7F);
    sel_echo = echo_pend_q && !tx_lock_q;
    pr_valid = sel_echo || (tx_act_q && !drop);
    pr_data  = sel_echo ? {1'b0, echo_q} : cond;
    tx_done  = tx_act_q && (drop || (!sel_echo && pr_ready));
    tx_idle  = !tx_act_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_buf_q    <= '0;
      tx_act_q    <= 1'b0;
      echo_q      <= '0;
      echo_pend_q <= 1'b0;
      tx_lock_q   <= 1'b0;
    end else begin
      if (wr_stb) begin
        tx_buf_q <= wr_data;
        tx_act_q <= 1'b1;
      end else if (tx_done) begin
        tx_act_q <= 1'b0;
      end
      if (echo_stb && !echo_pend_q) begin
        echo_q      <= echo_data;
        echo_pend_q <= 1'b1;
      end else if (sel_echo && pr_ready) begin
        echo_pend_q <= 1'b0;
      end
      tx_lock_q <= tx_act_q && !drop && !sel_echo && !pr_ready;
    end
  end

  a_r13_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_valid && !pr_ready) |=> pr_valid);

  a_r13_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_valid && !pr_ready && !wr_stb) |=> $stable(pr_data));

endmodule

// File: rtl/conio_flags.sv
module conio_flags
  import conio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  bus_op_e           op_kind,
  input  logic [CHAR_W-1:0] op_data,
  input  logic              kb_valid,
  input  logic              kb_break,
  input  logic [CHAR_W-1:0] kb_store,
  input  logic              poll_tick,
  input  logic              tx_done,
  input  logic              tx_idle,
  output logic [CHAR_W-1:0] status,
  output logic [CHAR_W-1:0] rx_buf,
  output logic              irq,
  output logic              half_dup
);
  logic rd_q, fdx_q, chp_q, arm_q, req_q, busy_q, ovr_q, brk_q;
  logic rd_n, fdx_n, chp_n, arm_n, req_n, busy_n, ovr_n, brk_n;
  logic [CHAR_W-1:0] buf_q, buf_n;
  logic wr_now, rd_ready;

  always_comb begin
    rd_n = rd_q;  fdx_n = fdx_q; chp_n = chp_q; arm_n = arm_q;
    req_n = req_q; busy_n = busy_q; ovr_n = ovr_q; brk_n = brk_q;
    buf_n = buf_q;
    rd_ready = 1'b0;
    wr_now = op_valid && (op_kind == OP_WDATA);

    if (op_valid) begin
      case (op_kind)
        OP_CMD: begin
          case (op_data[CF_INT+1:CF_INT])
            2'b01: arm_n = 1'b1;
            2'b10: begin arm_n = 1'b0; req_n = 1'b0; end
            default: ;
          endcase
          fdx_n = apply_field(op_data[CF_DUP+1:CF_DUP], fdx_q);
          rd_n  = apply_field(op_data[CF_DIR+1:CF_DIR], rd_q);
          if (rd_n != rd_q) begin
            rd_ready = rd_n ? chp_q : (tx_idle || tx_done);
            if (rd_ready) begin
              busy_n = 1'b0;
              if (arm_n) req_n = 1'b1;
            end else begin
              busy_n = 1'b1;
              req_n  = 1'b0;
            end
          end else begin
            ovr_n = 1'b0;
          end
        end
        OP_RDATA: begin
          chp_n = 1'b0;
          if (rd_q) begin
            busy_n = 1'b1;
            ovr_n  = 1'b0;
          end
        end
        OP_WDATA: begin
          if (!rd_q) busy_n = 1'b1;
        end
        default: ;
      endcase
    end

    if (tx_done && !wr_now && !rd_n) begin
      busy_n = 1'b0;
      if (arm_n) req_n = 1'b1;
    end

    if (poll_tick) brk_n = 1'b0;

    if (kb_valid) begin
      if (rd_n) begin
        busy_n = 1'b0;
        if (arm_n) req_n = 1'b1;
        if (chp_n) ovr_n = 1'b1;
      end
      chp_n = 1'b1;
      buf_n = kb_store;
    end

    if (kb_break) begin
      brk_n = 1'b1;
      buf_n = '0;
      if (rd_n) begin
        busy_n = 1'b0;
        if (arm_n) req_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b1; fdx_q <= 1'b1; chp_q <= 1'b0; arm_q <= 1'b0;
      req_q <= 1'b0; busy_q <= 1'b1; ovr_q <= 1'b0; brk_q <= 1'b0;
      buf_q <= '0;
    end else begin
      rd_q <= rd_n; fdx_q <= fdx_n; chp_q <= chp_n; arm_q <= arm_n;
      req_q <= req_n; busy_q <= busy_n; ovr_q <= ovr_n; brk_q <= brk_n;
      buf_q <= buf_n;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_OVR]  = ovr_q;
    status[ST_BRK]  = brk_q;
    status[ST_BUSY] = busy_q;
    status[ST_EX]   = ovr_q | brk_q;
  end

  assign rx_buf   = buf_q;
  assign irq      = req_q;
  assign half_dup = !fdx_q;

  a_r3_irq_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> arm_q);

  a_r6_read_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_RDATA && rd_q && !kb_valid && !kb_break)
      |=> (busy_q && !ovr_q));

  a_r7_write_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_WDATA && !rd_q) |=> busy_q);

  a_r8_second_char_overruns: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_valid && chp_q && rd_q && !op_valid) |=> ovr_q);

  a_r10_break_visible: assert property (@(posedge clk) disable iff (!rst_n)
    kb_break |=> brk_q);

endmodule

// File: rtl/conio_ctrl.sv
module conio_ctrl
  import conio_pkg::*;
#(
  parameter int POLL_PERIOD = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [1:0] op_kind,
  input  logic [7:0] op_data,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic       kb_valid,
  input  logic [7:0] kb_data,
  input  logic       kb_break,
  output logic       pr_valid,
  output logic [7:0] pr_data,
  input  logic       pr_ready,
  input  logic       cfg_ksr,
  input  logic       cfg_wide
);
  bus_op_e           op_e;
  logic [CHAR_W-1:0] store_ch, status, rx_buf;
  logic [6:0]        echo_ch;
  logic              echo_nz, poll_tick, tx_done, tx_idle, half_dup;
  logic              wr_stb, echo_stb;

  assign op_e     = bus_op_e'(op_kind);
  assign wr_stb   = op_valid && (op_e == OP_WDATA);
  assign echo_stb = kb_valid && !kb_break && half_dup && echo_nz;

  conio_rx_cond #(.POLL_PERIOD(POLL_PERIOD)) u_rx (
    .clk(clk), .rst_n(rst_n), .kb_data(kb_data),
    .cfg_ksr(cfg_ksr), .cfg_wide(cfg_wide),
    .store_ch(store_ch), .echo_ch(echo_ch), .echo_nz(echo_nz),
    .poll_tick(poll_tick)
  );

  conio_tx_path u_tx (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(op_data),
    .echo_stb(echo_stb), .echo_data(echo_ch),
    .cfg_ksr(cfg_ksr), .cfg_wide(cfg_wide), .pr_ready(pr_ready),
    .pr_valid(pr_valid), .pr_data(pr_data),
    .tx_done(tx_done), .tx_idle(tx_idle)
  );

  conio_flags u_flags (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_e),
    .op_data(op_data), .kb_valid(kb_valid), .kb_break(kb_break),
    .kb_store(store_ch), .poll_tick(poll_tick),
    .tx_done(tx_done), .tx_idle(tx_idle),
    .status(status), .rx_buf(rx_buf), .irq(irq), .half_dup(half_dup)
  );

  always_comb begin
    bus_rdata = '0;
    if (op_valid && op_e == OP_RDATA)      bus_rdata = rx_buf;
    else if (op_valid && op_e == OP_SENSE) bus_rdata = status;
  end

endmodule

// File: tb/conio_ctrl_tb_top.sv
module conio_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic [7:0] op_data = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;
  logic       kb_valid = 1'b0;
  logic [7:0] kb_data = 8'd0;
  logic       kb_break = 1'b0;
  logic       pr_valid;
  logic [7:0] pr_data;
  logic       pr_ready = 1'b1;
  logic       cfg_ksr = 1'b0;
  logic       cfg_wide = 1'b1;

  always #2 clk = ~clk;

  conio_ctrl #(.POLL_PERIOD(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_data(op_data), .bus_rdata(bus_rdata), .irq(irq),
    .kb_valid(kb_valid), .kb_data(kb_data), .kb_break(kb_break),
    .pr_valid(pr_valid), .pr_data(pr_data), .pr_ready(pr_ready),
    .cfg_ksr(cfg_ksr), .cfg_wide(cfg_wide)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] plog [64];
  int plog_n = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (rst_n && pr_valid && pr_ready) begin
      if (plog_n < 64) plog[plog_n] <= pr_data;
      plog_n <= plog_n + 1;
    end
  end

  // kinds: 0 cmd, 1 read, 2 write, 3 sense, 4 keyboard char
  // vector = {req[3:0], kind[3:0], data[7:0], expected[7:0]}
  localparam int NV = 26;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, 4'd3, 8'h00, 8'h08},  // R1 reset status
    {4'd8, 4'd4, 8'h61, 8'h00},  // R8 char in read mode
    {4'd8, 4'd3, 8'h00, 8'h00},  // R8 busy cleared
    {4'd6, 4'd1, 8'h00, 8'h61},  // R6 read buffer
    {4'd6, 4'd3, 8'h00, 8'h08},  // R6 busy set again
    {4'd8, 4'd4, 8'h41, 8'h00},  // R8
    {4'd8, 4'd4, 8'h42, 8'h00},  // R8 second char, overrun
    {4'd2, 4'd3, 8'h00, 8'h84},  // R2 overrun plus examine bit
    {4'd5, 4'd0, 8'h00, 8'h00},  // R5 no-change command
    {4'd5, 4'd3, 8'h00, 8'h00},  // R5 overrun cleared
    {4'd6, 4'd1, 8'h00, 8'h42},  // R6
    {4'd6, 4'd3, 8'h00, 8'h08},  // R6
    {4'd4, 4'd0, 8'h08, 8'h00},  // R4 to write, printer idle
    {4'd4, 4'd3, 8'h00, 8'h00},  // R4 busy clear
    {4'd7, 4'd2, 8'h55, 8'h00},  // R7 write
    {4'd7, 4'd3, 8'h00, 8'h08},  // R7 busy during transfer
    {4'd7, 4'd3, 8'h00, 8'h00},  // R7 busy clear after completion
    {4'd8, 4'd4, 8'h37, 8'h00},  // R8 char in write mode sets pending only
    {4'd4, 4'd0, 8'h04, 8'h00},  // R4 to read with char pending
    {4'd4, 4'd3, 8'h00, 8'h00},  // R4 busy clear
    {4'd6, 4'd1, 8'h00, 8'h37},  // R6
    {4'd4, 4'd0, 8'h08, 8'h00},  // R4 to write
    {4'd4, 4'd0, 8'h04, 8'h00},  // R4 to read, nothing pending
    {4'd4, 4'd3, 8'h00, 8'h08},  // R4 busy set
    {4'd3, 4'd0, 8'h0C, 8'h00},  // R3 field value 11 keeps direction
    {4'd3, 4'd3, 8'h00, 8'h08}   // R3 still read mode, busy unchanged
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  task automatic bus(input logic [1:0] k, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_data = d;
    #1 r = bus_rdata;
    @(posedge clk);
    #1 op_valid = 1'b0; op_data = 8'd0;
  endtask

  task automatic key(input logic [7:0] d, input logic brk);
    @(negedge clk);
    kb_valid = !brk; kb_break = brk; kb_data = d;
    @(posedge clk);
    #1 kb_valid = 1'b0; kb_break = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  task automatic sense_is(input string tag, input logic [7:0] exp);
    logic [7:0] r;
    bus(2'd3, 8'h00, r);
    check(tag, r, exp);
  endtask

  task automatic read_is(input string tag, input logic [7:0] exp);
    logic [7:0] r;
    bus(2'd1, 8'h00, r);
    check(tag, r, exp);
  endtask

  task automatic cmd(input logic [7:0] d);
    logic [7:0] r;
    bus(2'd0, d, r);
  endtask

  task automatic wr(input logic [7:0] d);
    logic [7:0] r;
    bus(2'd2, d, r);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int base;
    logic [7:0] r;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 pr_valid", {7'd0, pr_valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq, kd;
      logic [7:0] dd, ex;
      {rq, kd, dd, ex} = VEC[i];
      if (kd == 4'd4) key(dd, 1'b0);
      else begin
        bus(kd[1:0], dd, r);
        if (kd == 4'd1 || kd == 4'd3)
          check($sformatf("R%0d vector %0d", rq, i), r, ex);
      end
    end
    check("R7 printed char", plog[plog_n-1], 8'h55);

    // R3/R8 interrupt arm, request, disarm
    do_reset();
    cmd(8'h40);
    key(8'h31, 1'b0);
    check("R8 irq after char", {7'd0, irq}, 8'h01);
    cmd(8'h80);
    check("R3 disarm withdraws", {7'd0, irq}, 8'h00);
    read_is("R6 read after disarm", 8'h31);
    // R4 request on direction change, withdrawn when busy sets
    cmd(8'h48);
    check("R4 irq to write idle", {7'd0, irq}, 8'h01);
    cmd(8'h04);
    check("R4 irq withdrawn", {7'd0, irq}, 8'h00);
    sense_is("R4 busy set", 8'h08);

    // R9 receive conditioning
    do_reset();
    cfg_ksr = 1'b1;
    key(8'h71, 1'b0);
    read_is("R9 ksr fold", 8'hD1);
    key(8'h31, 1'b0);
    read_is("R9 ksr high bit", 8'hB1);
    cfg_ksr = 1'b0; cfg_wide = 1'b0;
    key(8'hE1, 1'b0);
    read_is("R9 7-bit mask", 8'h61);
    cfg_wide = 1'b1;
    key(8'hE1, 1'b0);
    read_is("R9 8-bit keep", 8'hE1);

    // R10 break
    do_reset();
    key(8'h00, 1'b1);
    sense_is("R10 break status", 8'h24);
    read_is("R10 break buffer", 8'h00);
    idle(70);
    sense_is("R10 break cleared by poll", 8'h08);

    // R11 half-duplex echo
    do_reset();
    cmd(8'h20);
    base = plog_n;
    key(8'hE2, 1'b0);
    idle(2);
    check("R11 echo count", 8'(plog_n - base), 8'd1);
    check("R11 echo value", plog[plog_n-1], 8'h62);
    key(8'h80, 1'b0);
    idle(2);
    check("R11 zero not echoed", 8'(plog_n - base), 8'd1);

    // R12 output conditioning and dropping
    do_reset();
    cmd(8'h08);
    cfg_wide = 1'b0;
    base = plog_n;
    wr(8'h00);
    idle(1);
    sense_is("R12 NUL completes", 8'h00);
    wr(8'h7F);
    idle(1);
    sense_is("R12 DEL completes", 8'h00);
    check("R12 nothing printed", 8'(plog_n - base), 8'd0);
    cfg_ksr = 1'b1;
    wr(8'h7A);
    idle(2);
    check("R12 ksr fold", plog[plog_n-1], 8'h5A);
    wr(8'hE1);
    idle(2);
    check("R12 ksr 7-bit", plog[plog_n-1], 8'h41);
    cfg_ksr = 1'b0; cfg_wide = 1'b1;
    base = plog_n;
    wr(8'h00);
    idle(2);
    check("R12 8-bit NUL sent", 8'(plog_n - base), 8'd1);

    // R13/R7 stall and retry
    do_reset();
    cmd(8'h48);
    pr_ready = 1'b0;
    base = plog_n;
    wr(8'hA5);
    idle(5);
    check("R13 valid held", {7'd0, pr_valid}, 8'h01);
    check("R13 data held", pr_data, 8'hA5);
    sense_is("R13 busy during stall", 8'h08);
    pr_ready = 1'b1;
    idle(3);
    check("R13 delivered once", 8'(plog_n - base), 8'd1);
    check("R13 delivered value", plog[plog_n-1], 8'hA5);
    sense_is("R7 busy clear after stall", 8'h00);
    check("R7 irq armed", {7'd0, irq}, 8'h01);

    report();
    $finish;
  end

endmodule